// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a real-time clock for a simple 32-bit peripheral bus with APB-style timing. A prescaler divides the bus clock down to a one-cycle pulse once per second. Each pulse advances a 32-bit seconds counter that wraps modulo 2^32. Software can load the counter with any value and can program a match value. When the counter becomes equal to the match value, a raw alarm flag is set. The flag passes through a one-bit enable mask to a single interrupt line.

The alarm is event driven. The counter and match value are compared only when something changes one of them: a tick, a load write or a match write. This means that writing a match value equal to the current count, or loading the count value that is already in the match register, raises the alarm in the same cycle as the write. A cleared alarm stays cleared while the two values remain equal and nothing changes them. A read-only identification area sits in the last eight words of the 4 KB window. The control word is fixed at "enabled".

Top module: `rtc_secs_top`

## Requirements
- R1: The count register (word offset 0x00) returns the live count, which increases by exactly one every TICK_DIV bus clock cycles and otherwise holds.
- R2: A write to the load register (0x08) sets the live count to the written value at that clock edge; a read of 0x08 returns the last value written there, not the live count. A load write and a tick in the same cycle resolve in favour of the load.
- R3: The count wraps from 0xFFFFFFFF to 0x00000000, and a match value of 0 raises the alarm on that wrap.
- R4: The raw alarm flag (bit 0 of 0x14) sets when a tick advances the count to the value held in the match register (0x04).
- R5: A write to the match register or the load register that makes count and match equal sets the raw alarm flag at that write's clock edge, without waiting for a tick.
- R6: The mask register (0x10) stores only bit 0; bits 31:1 always read as zero.
- R7: A write to the clear register (0x1C) with bit 0 set clears the raw flag; a write with bit 0 clear leaves the flag unchanged. If the same edge also brings an alarm event, the set wins.
- R8: The masked status (0x18) and the interrupt output both equal raw flag AND mask bit, and follow either one with no extra delay.
- R9: The control register (0x0C) always reads 1, and writes to it have no effect.
- R10: Reads of word offsets 0xFE0 through 0xFFC return the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, one per word, in that ascending address order.
- R11: Reads of the clear register or of any unmapped offset return 0. Writes to the count, raw status, masked status, control, ID or unmapped offsets change no state.
- R12: Reset clears the count, match, load, mask and raw flag to zero and restarts the prescaler.
- R13: The raw flag never sets unless a tick, a load write or a match write brings count and match to equal values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, which also drives the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase; a write takes effect when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address in the window; bits 1:0 are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, driven while psel is high and pwrite is low, otherwise 0 |
| irq | output | 1 | Alarm interrupt, equal to raw flag AND mask |

## Verification
A wrong prescaler phase or counter value shows at the count register within one second period, because every read there is compared against an arithmetic model of the tick times. A flag that sets on the wrong event, or that fails to clear, appears on the irq pin and on the status words at the first read after the edge concerned. The bench checks both in every read it makes. Because every one of the 1024 word offsets is read back, and every non-writable offset is written, a decode fault shows up either as a wrong read value or as corrupted match, load or mask contents in the next sweep.

// File: rtl/rtc_secs_pkg.sv
package rtc_secs_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int WIDX_W = ADDR_W - 2;

  // word indices inside the 4 KB window
  localparam logic [WIDX_W-1:0] W_COUNT = 10'h000;
  localparam logic [WIDX_W-1:0] W_MATCH = 10'h001;
  localparam logic [WIDX_W-1:0] W_LOAD  = 10'h002;
  localparam logic [WIDX_W-1:0] W_CTRL  = 10'h003;
  localparam logic [WIDX_W-1:0] W_MASK  = 10'h004;
  localparam logic [WIDX_W-1:0] W_RAW   = 10'h005;
  localparam logic [WIDX_W-1:0] W_MSKD  = 10'h006;
  localparam logic [WIDX_W-1:0] W_CLEAR = 10'h007;
  localparam logic [WIDX_W-4:0] W_IDBASE = 7'h7F; // upper bits of 0xFE0..0xFFC

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        if (pre_q == LAST) pre_d = '0;
        else               pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = (pre_q == LAST);

      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/rtc_count_alarm.sv
module rtc_count_alarm #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld_we,
  input  logic [W-1:0] ld_val,
  input  logic         mt_we,
  input  logic [W-1:0] mt_val,
  input  logic         clr_we,
  input  logic         clr_bit,
  output logic [W-1:0] count,
  output logic [W-1:0] match,
  output logic         raw
);
  logic [W-1:0] cnt_d, mt_d;
  logic         raw_d, evt, hit;

  always_comb begin
    if (ld_we)     cnt_d = ld_val;
    else if (tick) cnt_d = count + 1'b1;
    else           cnt_d = count;
    mt_d = mt_we ? mt_val : match;
    evt  = tick | ld_we | mt_we;
    hit  = evt && (cnt_d == mt_d);
    if (hit)                  raw_d = 1'b1;
    else if (clr_we & clr_bit) raw_d = 1'b0;
    else                      raw_d = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      match <= '0;
      raw   <= 1'b0;
    end else begin
      count <= cnt_d;
      match <= mt_d;
      raw   <= raw_d;
    end
  end

  AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> count == $past(ld_val)); // R2
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_we) |=> count == W'($past(count) + 1'b1)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_we) |=> $stable(count)); // R1
  AST_MATCH_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_we && !ld_we && !tick && mt_val == count) |=> raw); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bit && !tick && !ld_we && !mt_we) |=> !raw); // R7
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_we && !mt_we && !raw) |=> !raw); // R13
endmodule

// File: rtl/rtc_secs_top.sv
module rtc_secs_top
  import rtc_secs_pkg::*;
#(
  parameter int TICK_DIV = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  logic [WIDX_W-1:0] widx;
  logic              wr_acc, rd_acc, tick, raw;
  logic              we_ld, we_mt, we_mask, we_clr;
  logic [DATA_W-1:0] count, match, load_q, load_d;
  logic              mask_q, mask_d;
  logic [1:0]        unused_lsb;

  assign widx       = paddr[ADDR_W-1:2];
  assign unused_lsb = paddr[1:0];
  assign wr_acc     = psel & penable & pwrite;
  assign rd_acc     = psel & ~pwrite;
  assign we_ld      = wr_acc && (widx == W_LOAD);
  assign we_mt      = wr_acc && (widx == W_MATCH);
  assign we_mask    = wr_acc && (widx == W_MASK);
  assign we_clr     = wr_acc && (widx == W_CLEAR);

  rtc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rtc_count_alarm #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld_we(we_ld), .ld_val(pwdata),
    .mt_we(we_mt), .mt_val(pwdata),
    .clr_we(we_clr), .clr_bit(pwdata[0]),
    .count(count), .match(match), .raw(raw)
  );

  always_comb begin
    load_d = we_ld   ? pwdata    : load_q;
    mask_d = we_mask ? pwdata[0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      mask_q <= 1'b0;
    end else begin
      load_q <= load_d;
      mask_q <= mask_d;
    end
  end

  assign irq = raw & mask_q;

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      case (widx)
        W_COUNT: prdata = count;
        W_MATCH: prdata = match;
        W_LOAD:  prdata = load_q;
        W_CTRL:  prdata = DATA_W'(1);
        W_MASK:  prdata = DATA_W'(mask_q);
        W_RAW:   prdata = DATA_W'(raw);
        W_MSKD:  prdata = DATA_W'(irq);
        default: begin
          if (widx[WIDX_W-1:3] == W_IDBASE)
            prdata = DATA_W'(ident_byte(widx[2:0]));
        end
      endcase
    end
  end

  AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && widx == W_MASK) |-> prdata[DATA_W-1:1] == '0); // R6
  AST_CTRL_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && widx == W_CTRL) |-> prdata == DATA_W'(1)); // R9
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_mask |=> $stable(mask_q)); // R11
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && widx == W_CLEAR) |-> prdata == '0); // R11
endmodule

// File: tb/rtc_secs_top_tb_top.sv
module rtc_secs_top_tb_top;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rtc_secs_top #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq)
  );

  // arithmetic model built from the requirements
  int unsigned m_pre;
  logic [31:0] m_cnt, m_mt, m_ld;
  logic        m_mask, m_raw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_mt <= 0; m_ld <= 0; m_mask <= 0; m_raw <= 0;
    end else begin
      logic t, wr, ev;
      logic [31:0] nc, nm;
      logic [9:0] w;
      t  = (m_pre == DIV - 1);
      wr = psel & penable & pwrite;
      w  = paddr[11:2];
      m_pre <= t ? 0 : m_pre + 1;
      nc = (wr && w == 10'd2) ? pwdata : (t ? m_cnt + 32'd1 : m_cnt);
      nm = (wr && w == 10'd1) ? pwdata : m_mt;
      ev = t | (wr && (w == 10'd1 || w == 10'd2));
      m_cnt <= nc;
      m_mt  <= nm;
      if (wr && w == 10'd2) m_ld <= pwdata;
      if (wr && w == 10'd4) m_mask <= pwdata[0];
      if (ev && nc == nm) m_raw <= 1'b1;
      else if (wr && w == 10'd7 && pwdata[0]) m_raw <= 1'b0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [9:0] w;
    logic [7:0] ids [8];
    ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    w = a[11:2];
    if (w >= 10'h3F8) return {24'h0, ids[w - 10'h3F8]};
    case (w)
      10'd0: return m_cnt;
      10'd1: return m_mt;
      10'd2: return m_ld;
      10'd3: return 32'd1;
      10'd4: return {31'h0, m_mask};
      10'd5: return {31'h0, m_raw};
      10'd6: return {31'h0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #3;
    check(tag, prdata, exp_read(a));
    check({tag, " irq (R8)"}, {31'h0, irq}, {31'h0, m_raw & m_mask});
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_secs(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    @(negedge clk); #3;
    check("R12 count after reset", prdata, 32'h0);
    check("R12 irq after reset", {31'h0, irq}, 32'h0);
    rd(12'h000, "R12 count"); rd(12'h004, "R12 match"); rd(12'h008, "R12 load");
    rd(12'h010, "R12 mask"); rd(12'h014, "R12 raw");
    // R10 ID bytes
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i * 4), "R10 id byte");
    // R1 counting, sampled several times
    for (int i = 0; i < 5; i++) begin wait_secs(1); rd(12'h000, "R1 count"); end
    // R2 load and readback
    wr(12'h008, 32'h1234_5678);
    rd(12'h000, "R2 count after load"); rd(12'h008, "R2 load readback");
    wait_secs(2);
    rd(12'h008, "R2 load holds"); rd(12'h000, "R2 count advanced");
    // R6 mask bit only
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, "R6 mask all ones");
    wr(12'h010, 32'hFFFF_FFFE); rd(12'h010, "R6 mask bit0 zero");
    wr(12'h010, 32'h1);
    // R5 match write equal to count (right after a load so no tick races)
    wr(12'h008, 32'd500); wr(12'h004, 32'd500);
    rd(12'h014, "R5 raw after match write"); rd(12'h018, "R8 masked status");
    // R7 clear with bit0=0 keeps, then bit0=1 clears
    wr(12'h01C, 32'hFFFF_FFFE); rd(12'h014, "R7 clear bit0 zero keeps");
    wr(12'h01C, 32'h1);         rd(12'h014, "R7 clear bit0 one");
    rd(12'h014, "R13 stays clear while equal");
    // R5 via load
    wr(12'h004, 32'd900); wr(12'h008, 32'd900);
    rd(12'h014, "R5 raw after load write");
    // R8 mask gating both ways
    wr(12'h010, 32'h0); rd(12'h018, "R8 masked off");
    wr(12'h010, 32'h1); rd(12'h018, "R8 masked on");
    wr(12'h01C, 32'h1);
    // R4 tick reaches match
    wr(12'h008, 32'd50); wr(12'h004, 32'd52);
    rd(12'h014, "R4 raw before");
    wait_secs(3);
    rd(12'h014, "R4 raw after ticks"); rd(12'h000, "R4 count");
    wr(12'h01C, 32'h1);
    // R3 wrap
    wr(12'h008, 32'hFFFF_FFFF); wr(12'h004, 32'h0); wr(12'h01C, 32'h1);
    rd(12'h014, "R3 raw before wrap");
    wait_secs(2);
    rd(12'h000, "R3 count after wrap"); rd(12'h014, "R3 raw after wrap");
    // R9 control
    wr(12'h00C, 32'h0); rd(12'h00C, "R9 control");
    // R11 writes to non-writable offsets are ignored
    wr(12'h010, 32'h1); wr(12'h004, 32'hA5A5_0000); wr(12'h008, 32'h0000_0100);
    for (int a = 0; a < 1024; a++) begin
      if (a != 1 && a != 2 && a != 4 && a != 7) wr(12'(a * 4), 32'hFFFF_FFFF);
    end
    rd(12'h004, "R11 match kept"); rd(12'h008, "R11 load kept");
    rd(12'h010, "R11 mask kept"); rd(12'h014, "R11 raw kept");
    // R11/R10 full read sweep
    for (int a = 0; a < 1024; a++) rd(12'(a * 4), "R11 read sweep");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule